// File: doc/BRIEF.md
# Multistandard 4/8-Point Inverse Integer Transform

This block computes one-dimensional inverse integer transforms for a family of video decoders. Each clock it accepts one vector of eight signed 16-bit coefficients and a 4-bit mode code. The mode code picks both the coefficient family and the transform length. Eight-point modes split the work into two halves. One half combines the even-indexed inputs with three coefficients. The other half combines the odd-indexed inputs with four coefficients. A final add/subtract stage joins the two halves into eight results. Four-point modes steer the first four input lanes into the even half and reuse its adders. No arithmetic is added for them.

Every constant product is built from shifted copies of the input and additions, so there are no general multipliers. The result vector leaves a fixed number of cycles after it enters, and a new vector may enter on every cycle. Transposition for a second pass, final rounding, normalisation shifts and quantisation are done outside the block.

Top module: `itx_multistd`

## Requirements
- R1: Lane n of `in_data` (bits n*16 upward) is input y_n, and lane k of `out_data` (bits k*28 upward) is result k. For modes 0 to 4, result k is the sum over n of y_n times cos((2k+1)nπ/16) in integer form. Reduce m=(2k+1)n mod 32 into 0..8 and take the sign from the cosine. Then the weight is A when m is 0 or 4, B when m=1, C when m=3, D when m=5, E when m=7, F when m=2 and G when m=6. The sets {A,B,C,D,E,F,G} are: mode 0 {12,16,15,9,4,16,6}, mode 1 {8,10,9,6,2,10,4}, mode 2 {362,502,426,284,100,473,196}, mode 3 {8,12,10,6,3,8,4}, mode 4 {64,89,75,50,18,83,36}.
- R2: For modes 5 to 9, results 0..3 are the four-point transform of lanes 0..3 with weights {H,I,J}. The rows are: result 0 = H,I,H,J; result 1 = H,J,-H,-I; result 2 = H,-J,-H,I; result 3 = H,-I,H,-J. The sets are: mode 5 {17,22,10}, mode 6 {128,167,70}, mode 7 {2,3,1}, mode 8 {1,1,half}, mode 9 {64,83,36}.
- R3: In mode 8 each "half" product is the input shifted right arithmetically by one bit, which rounds toward minus infinity (-3 gives -2). The sign of the row is applied after the shift.
- R4: In modes 5 to 9, input lanes 4..7 have no effect, and output lanes 4..7 are zero.
- R5: Mode codes 10 to 15 give an all-zero result vector, and its valid flag still follows `in_valid`.
- R6: `out_valid` and the matching result appear after the third rising edge, counting the edge that samples `in_valid`. Vectors may enter back to back on every cycle, and gaps pass through unchanged.
- R7: Results are exact over the full input range in every mode. The worst case is mode 2 with full-scale inputs, and it still fits the 28-bit two's-complement lanes.
- R8: While `rst_n` is low, and until the first vector accepted after reset reaches the output, `out_valid` is 0 and `out_data` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Marks a vector on `in_data` |
| mode | input | 4 | Coefficient family and transform length code |
| in_data | input | 128 | Eight signed 16-bit input lanes |
| out_valid | output | 1 | Marks a result vector on `out_data` |
| out_data | output | 224 | Eight signed 28-bit result lanes |

## Verification
On every cycle, assertions check several things. The valid flag must trail the input by exactly three edges. Four-point modes must leave the upper result lanes at zero, and unassigned codes must give zero vectors. The final add/subtract stage must never overflow, and a section fed zeros must output zeros. The bench alone can show that each family's weights are correct and that the right lanes feed each weight. It also shows that mode 8 rounds its half terms downward and that ignored lanes really have no effect. It does this by comparing every result against an independent cosine-index model under impulses, random vectors, full-scale patterns and a mixed stream with gaps.

// File: rtl/itx_pkg.sv
package itx_pkg;

  localparam int N_EVEN_SETS = 10;
  localparam int N_ODD_SETS  = 5;
  localparam int N_HALF      = 4;
  localparam int COEF_BITS   = 10;
  localparam int HALF_SET    = 8;

  localparam logic [3:0] LAST_8PT_CODE = 4'd4;
  localparam logic [3:0] LAST_4PT_CODE = 4'd9;

  typedef enum logic [1:0] {
    SHAPE_NONE = 2'd0,
    SHAPE_8PT  = 2'd1,
    SHAPE_4PT  = 2'd2
  } shape_e;

  function automatic shape_e mode_shape(logic [3:0] code);
    if (code <= LAST_8PT_CODE) return SHAPE_8PT;
    if (code <= LAST_4PT_CODE) return SHAPE_4PT;
    return SHAPE_NONE;
  endfunction

  // Constant product by shift-and-add; with a constant weight this folds to adders.
  function automatic longint shift_add_mul(longint x, int weight);
    longint acc;
    acc = 0;
    for (int b = 0; b < COEF_BITS; b++) begin
      if (weight[b]) acc += x <<< b;
    end
    return acc;
  endfunction

  // Even-half weights per set: idx 0 = dc weight, 1 = large, 2 = small.
  // Sets 0..4 serve the 8-point modes, sets 5..9 the 4-point modes.
  function automatic int even_coef(int sel, int idx);
    int dc, lg, sm;
    case (sel)
      0: begin dc = 12;  lg = 16;  sm = 6;   end
      1: begin dc = 8;   lg = 10;  sm = 4;   end
      2: begin dc = 362; lg = 473; sm = 196; end
      3: begin dc = 8;   lg = 8;   sm = 4;   end
      4: begin dc = 64;  lg = 83;  sm = 36;  end
      5: begin dc = 17;  lg = 22;  sm = 10;  end
      6: begin dc = 128; lg = 167; sm = 70;  end
      7: begin dc = 2;   lg = 3;   sm = 1;   end
      8: begin dc = 1;   lg = 1;   sm = 0;   end
      9: begin dc = 64;  lg = 83;  sm = 36;  end
      default: begin dc = 0; lg = 0; sm = 0; end
    endcase
    if (idx == 0) return dc;
    if (idx == 1) return lg;
    return sm;
  endfunction

  function automatic bit even_half(int sel);
    return (sel == HALF_SET);
  endfunction

  // Odd-half weights per set in descending magnitude order w0 > w1 > w2 > w3.
  function automatic int odd_coef(int sel, int idx);
    int w0, w1, w2, w3;
    case (sel)
      0: begin w0 = 16;  w1 = 15;  w2 = 9;   w3 = 4;   end
      1: begin w0 = 10;  w1 = 9;   w2 = 6;   w3 = 2;   end
      2: begin w0 = 502; w1 = 426; w2 = 284; w3 = 100; end
      3: begin w0 = 12;  w1 = 10;  w2 = 6;   w3 = 3;   end
      4: begin w0 = 89;  w1 = 75;  w2 = 50;  w3 = 18;  end
      default: begin w0 = 0; w1 = 0; w2 = 0; w3 = 0; end
    endcase
    case (idx)
      0: return w0;
      1: return w1;
      2: return w2;
      default: return w3;
    endcase
  endfunction

endpackage

// File: rtl/itx_in_stage.sv
module itx_in_stage
  import itx_pkg::*;
#(
  parameter int IW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [3:0]           mode,
  input  logic [2*N_HALF*IW-1:0] in_data,
  output logic                 v_q,
  output logic [3:0]           mode_q,
  output shape_e               shape_q,
  output logic signed [IW-1:0] ev_q [N_HALF],
  output logic signed [IW-1:0] od_q [N_HALF]
);

  shape_e shape_d;
  logic signed [IW-1:0] lane [2*N_HALF];

  assign shape_d = mode_shape(mode);

  for (genvar n = 0; n < 2*N_HALF; n++) begin : g_lane
    assign lane[n] = in_data[n*IW +: IW];
  end

  // Lane steering: 8-point splits even/odd lanes, 4-point feeds lanes 0..3
  // to the even half and silences the odd half, other codes silence both.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q     <= 1'b0;
      mode_q  <= '0;
      shape_q <= SHAPE_NONE;
      for (int k = 0; k < N_HALF; k++) begin
        ev_q[k] <= '0;
        od_q[k] <= '0;
      end
    end else begin
      v_q     <= in_valid;
      mode_q  <= mode;
      shape_q <= shape_d;
      for (int k = 0; k < N_HALF; k++) begin
        case (shape_d)
          SHAPE_8PT: begin
            ev_q[k] <= lane[2*k];
            od_q[k] <= lane[2*k+1];
          end
          SHAPE_4PT: begin
            ev_q[k] <= lane[k];
            od_q[k] <= '0;
          end
          default: begin
            ev_q[k] <= '0;
            od_q[k] <= '0;
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/itx_even_sec.sv
module itx_even_sec
  import itx_pkg::*;
#(
  parameter int IW = 16,
  parameter int AW = 28
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [3:0]           set_i,
  input  logic signed [IW-1:0] e_i [N_HALF],
  output logic signed [AW-1:0] r_q [N_HALF]
);

  logic signed [AW-1:0] cand [N_EVEN_SETS][N_HALF];
  logic signed [AW-1:0] r_d  [N_HALF];

  for (genvar s = 0; s < N_EVEN_SETS; s++) begin : g_set
    localparam int  WDC  = even_coef(s, 0);
    localparam int  WLG  = even_coef(s, 1);
    localparam int  WSM  = even_coef(s, 2);
    localparam bit  HALF = even_half(s);

    logic signed [AW-1:0] p_dc0, p_dc2, p_lg1, p_lg3, p_sm1, p_sm3;
    logic signed [AW-1:0] dc_sum, dc_dif;

    always_comb begin
      p_dc0 = AW'(shift_add_mul(longint'(e_i[0]), WDC));
      p_dc2 = AW'(shift_add_mul(longint'(e_i[2]), WDC));
      p_lg1 = AW'(shift_add_mul(longint'(e_i[1]), WLG));
      p_lg3 = AW'(shift_add_mul(longint'(e_i[3]), WLG));
      if (HALF) begin
        p_sm1 = AW'(longint'(e_i[1]) >>> 1);
        p_sm3 = AW'(longint'(e_i[3]) >>> 1);
      end else begin
        p_sm1 = AW'(shift_add_mul(longint'(e_i[1]), WSM));
        p_sm3 = AW'(shift_add_mul(longint'(e_i[3]), WSM));
      end
      dc_sum = p_dc0 + p_dc2;
      dc_dif = p_dc0 - p_dc2;
    end

    assign cand[s][0] = dc_sum + p_lg1 + p_sm3;
    assign cand[s][1] = dc_dif + p_sm1 - p_lg3;
    assign cand[s][2] = dc_dif - p_sm1 + p_lg3;
    assign cand[s][3] = dc_sum - p_lg1 - p_sm3;
  end

  always_comb begin
    for (int k = 0; k < N_HALF; k++) r_d[k] = '0;
    for (int s = 0; s < N_EVEN_SETS; s++) begin
      if (set_i == 4'(s)) begin
        for (int k = 0; k < N_HALF; k++) r_d[k] = cand[s][k];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < N_HALF; k++) r_q[k] <= '0;
    end else begin
      for (int k = 0; k < N_HALF; k++) r_q[k] <= r_d[k];
    end
  end

  logic feed_zero;
  assign feed_zero = (e_i[0] == '0) && (e_i[1] == '0) && (e_i[2] == '0) && (e_i[3] == '0);

  AST_EVEN_ZERO_IN: assert property (@(posedge clk) disable iff (!rst_n)
    feed_zero |=> (r_q[0] == '0 && r_q[1] == '0 && r_q[2] == '0 && r_q[3] == '0)); // R1

endmodule

// File: rtl/itx_odd_sec.sv
module itx_odd_sec
  import itx_pkg::*;
#(
  parameter int IW = 16,
  parameter int AW = 28
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [3:0]           set_i,
  input  logic signed [IW-1:0] o_i [N_HALF],
  output logic signed [AW-1:0] r_q [N_HALF]
);

  logic signed [AW-1:0] cand [N_ODD_SETS][N_HALF];
  logic signed [AW-1:0] r_d  [N_HALF];

  for (genvar s = 0; s < N_ODD_SETS; s++) begin : g_set
    localparam int W0 = odd_coef(s, 0);
    localparam int W1 = odd_coef(s, 1);
    localparam int W2 = odd_coef(s, 2);
    localparam int W3 = odd_coef(s, 3);

    // q<w>[i] is weight w applied to odd input i
    logic signed [AW-1:0] q0 [N_HALF];
    logic signed [AW-1:0] q1 [N_HALF];
    logic signed [AW-1:0] q2 [N_HALF];
    logic signed [AW-1:0] q3 [N_HALF];

    always_comb begin
      for (int i = 0; i < N_HALF; i++) begin
        q0[i] = AW'(shift_add_mul(longint'(o_i[i]), W0));
        q1[i] = AW'(shift_add_mul(longint'(o_i[i]), W1));
        q2[i] = AW'(shift_add_mul(longint'(o_i[i]), W2));
        q3[i] = AW'(shift_add_mul(longint'(o_i[i]), W3));
      end
    end

    assign cand[s][0] =  q0[0] + q1[1] + q2[2] + q3[3];
    assign cand[s][1] =  q1[0] - q3[1] - q0[2] - q2[3];
    assign cand[s][2] =  q2[0] - q0[1] + q3[2] + q1[3];
    assign cand[s][3] =  q3[0] - q2[1] + q1[2] - q0[3];
  end

  always_comb begin
    for (int k = 0; k < N_HALF; k++) r_d[k] = '0;
    for (int s = 0; s < N_ODD_SETS; s++) begin
      if (set_i == 4'(s)) begin
        for (int k = 0; k < N_HALF; k++) r_d[k] = cand[s][k];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < N_HALF; k++) r_q[k] <= '0;
    end else begin
      for (int k = 0; k < N_HALF; k++) r_q[k] <= r_d[k];
    end
  end

  logic feed_zero;
  assign feed_zero = (o_i[0] == '0) && (o_i[1] == '0) && (o_i[2] == '0) && (o_i[3] == '0);

  AST_ODD_ZERO_IN: assert property (@(posedge clk) disable iff (!rst_n)
    feed_zero |=> (r_q[0] == '0 && r_q[1] == '0 && r_q[2] == '0 && r_q[3] == '0)); // R1

endmodule

// File: rtl/itx_butterfly.sv
module itx_butterfly
  import itx_pkg::*;
#(
  parameter int AW = 28
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  shape_e               shape_i,
  input  logic signed [AW-1:0] ev_i [N_HALF],
  input  logic signed [AW-1:0] od_i [N_HALF],
  output logic signed [AW-1:0] y_q  [2*N_HALF]
);

  logic signed [AW:0]   wsum [N_HALF];
  logic signed [AW:0]   wdif [N_HALF];
  logic [N_HALF-1:0]    ovf;
  logic signed [AW-1:0] y_d  [2*N_HALF];

  always_comb begin
    for (int k = 0; k < N_HALF; k++) begin
      wsum[k] = (AW+1)'(ev_i[k]) + (AW+1)'(od_i[k]);
      wdif[k] = (AW+1)'(ev_i[k]) - (AW+1)'(od_i[k]);
      ovf[k]  = (wsum[k][AW] != wsum[k][AW-1]) || (wdif[k][AW] != wdif[k][AW-1]);
    end
    for (int k = 0; k < N_HALF; k++) begin
      case (shape_i)
        SHAPE_8PT: begin
          y_d[k]              = wsum[k][AW-1:0];
          y_d[2*N_HALF-1-k]   = wdif[k][AW-1:0];
        end
        SHAPE_4PT: begin
          y_d[k]              = ev_i[k];
          y_d[k+N_HALF]       = '0;
        end
        default: begin
          y_d[k]              = '0;
          y_d[k+N_HALF]       = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 2*N_HALF; k++) y_q[k] <= '0;
    end else begin
      for (int k = 0; k < 2*N_HALF; k++) y_q[k] <= y_d[k];
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (shape_i == SHAPE_8PT) |-> (ovf == '0)); // R7

endmodule

// File: rtl/itx_multistd.sv
module itx_multistd
  import itx_pkg::*;
#(
  parameter  int IN_W  = 16,
  parameter  int GROW  = 12,
  localparam int OUT_W = IN_W + GROW,
  localparam int LANES = 2 * N_HALF
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [3:0]             mode,
  input  logic [LANES*IN_W-1:0]  in_data,
  output logic                   out_valid,
  output logic [LANES*OUT_W-1:0] out_data
);

  logic                   v1_q, v2_q, v3_q;
  logic [3:0]             mode1_q;
  shape_e                 shape1_q, shape2_q;
  logic signed [IN_W-1:0]  ev1 [N_HALF];
  logic signed [IN_W-1:0]  od1 [N_HALF];
  logic signed [OUT_W-1:0] ev2 [N_HALF];
  logic signed [OUT_W-1:0] od2 [N_HALF];
  logic signed [OUT_W-1:0] y_q [LANES];

  itx_in_stage #(.IW(IN_W)) i_in (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .mode     (mode),
    .in_data  (in_data),
    .v_q      (v1_q),
    .mode_q   (mode1_q),
    .shape_q  (shape1_q),
    .ev_q     (ev1),
    .od_q     (od1)
  );

  itx_even_sec #(.IW(IN_W), .AW(OUT_W)) i_even (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (mode1_q),
    .e_i   (ev1),
    .r_q   (ev2)
  );

  itx_odd_sec #(.IW(IN_W), .AW(OUT_W)) i_odd (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (mode1_q),
    .o_i   (od1),
    .r_q   (od2)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v2_q     <= 1'b0;
      v3_q     <= 1'b0;
      shape2_q <= SHAPE_NONE;
    end else begin
      v2_q     <= v1_q;
      v3_q     <= v2_q;
      shape2_q <= shape1_q;
    end
  end

  itx_butterfly #(.AW(OUT_W)) i_bfly (
    .clk     (clk),
    .rst_n   (rst_n),
    .shape_i (shape2_q),
    .ev_i    (ev2),
    .od_i    (od2),
    .y_q     (y_q)
  );

  assign out_valid = v3_q;
  for (genvar k = 0; k < LANES; k++) begin : g_out
    assign out_data[k*OUT_W +: OUT_W] = y_q[k];
  end

  // Cycles since reset, saturating, so history checks never reach into reset.
  logic [1:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               warm_q <= 2'd0;
    else if (warm_q != 2'd3)  warm_q <= warm_q + 2'd1;
  end

  logic feed_4pt, feed_bad;
  assign feed_4pt = in_valid && (mode_shape(mode) == SHAPE_4PT);
  assign feed_bad = in_valid && (mode_shape(mode) == SHAPE_NONE);

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd3) |-> (out_valid == $past(in_valid, 3))); // R6

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd3 && $past(feed_4pt, 3)) |-> (out_data[LANES*OUT_W-1:N_HALF*OUT_W] == '0)); // R4

  AST_BAD_MODE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd3 && $past(feed_bad, 3)) |-> (out_valid && out_data == '0)); // R5

endmodule

// File: tb/test_itx_multistd.sv
module test_itx_multistd;

  localparam int IW = 16;
  localparam int OW = 28;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           in_valid = 1'b0;
  logic [3:0]     mode = '0;
  logic [8*IW-1:0] in_data = '0;
  wire            out_valid;
  wire [8*OW-1:0] out_data;

  always #5 clk = ~clk;

  itx_multistd i_itx_multistd (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .mode      (mode),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  string cur_tag = "R8";

  // weights in order A,B,C,D,E,F,G for modes 0..4
  int T8 [5][7] = '{'{12,16,15,9,4,16,6}, '{8,10,9,6,2,10,4},
                    '{362,502,426,284,100,473,196}, '{8,12,10,6,3,8,4},
                    '{64,89,75,50,18,83,36}};
  // weights H,I,J for modes 5..9; mode 8 J is the halving rule
  int T4 [5][3] = '{'{17,22,10}, '{128,167,70}, '{2,3,1}, '{1,1,0}, '{64,83,36}};

  function automatic logic [8*OW-1:0] model(int md, logic [8*IW-1:0] d);
    logic [8*OW-1:0] r;
    longint x [8];
    longint acc;
    r = '0;
    for (int n = 0; n < 8; n++) x[n] = longint'($signed(d[n*IW +: IW]));
    if (md < 5) begin
      for (int k = 0; k < 8; k++) begin
        acc = 0;
        for (int n = 0; n < 8; n++) begin
          int m, sg, ci;
          m = ((2*k+1)*n) % 32;
          if (m > 16) m = 32 - m;
          sg = 1;
          if (m > 8) begin sg = -1; m = 16 - m; end
          case (m)
            0, 4: ci = 0;
            1: ci = 1;
            3: ci = 2;
            5: ci = 3;
            7: ci = 4;
            2: ci = 5;
            default: ci = 6;
          endcase
          acc += longint'(sg * T8[md][ci]) * x[n];
        end
        r[k*OW +: OW] = acc[OW-1:0];
      end
    end else if (md < 10) begin
      for (int k = 0; k < 4; k++) begin
        acc = 0;
        for (int n = 0; n < 4; n++) begin
          int m, sg, ci;
          m = ((2*k+1)*n) % 16;
          if (m > 8) m = 16 - m;
          sg = 1;
          if (m > 4) begin sg = -1; m = 8 - m; end
          case (m)
            0, 2: ci = 0;
            1: ci = 1;
            default: ci = 2;
          endcase
          if (md == 8 && ci == 2) acc += longint'(sg) * (x[n] >>> 1);
          else                    acc += longint'(sg * T4[md-5][ci]) * x[n];
        end
        r[k*OW +: OW] = acc[OW-1:0];
      end
    end
    return r;
  endfunction

  logic [8*OW-1:0] exp_q [$];
  bit              val_q [$];
  string           tag_q [$];

  always @(posedge clk) begin
    if (rst_n) begin
      exp_q.push_back(model(int'(mode), in_data));
      val_q.push_back(in_valid);
      tag_q.push_back(cur_tag);
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      if (!rst_n) begin
        exp_q.delete(); val_q.delete(); tag_q.delete();
        n_chk++;
        if (out_valid !== 1'b0 || out_data !== '0) begin
          n_fail++;
          $display("FAIL R8: in reset valid=%0b data=%h expected valid=0 data=0", out_valid, out_data);
        end
      end else if (exp_q.size() < 3) begin
        n_chk++;
        if (out_valid !== 1'b0 || out_data !== '0) begin
          n_fail++;
          $display("FAIL R8: before first result valid=%0b data=%h expected valid=0 data=0", out_valid, out_data);
        end
      end else begin
        logic [8*OW-1:0] e;
        bit ev;
        string t;
        e  = exp_q.pop_front();
        ev = val_q.pop_front();
        t  = tag_q.pop_front();
        n_chk++;
        if (out_valid !== ev || (ev && out_data !== e)) begin
          n_fail++;
          $display("FAIL %s: valid=%0b data=%h expected valid=%0b data=%h", t, out_valid, out_data, ev, e);
        end
      end
    end
  end

  function automatic logic [8*IW-1:0] rnd_vec();
    logic [8*IW-1:0] d;
    for (int n = 0; n < 8; n++) d[n*IW +: IW] = IW'($urandom);
    return d;
  endfunction

  function automatic logic [8*IW-1:0] fill(int v_even, int v_odd);
    logic [8*IW-1:0] d;
    for (int n = 0; n < 8; n++) d[n*IW +: IW] = IW'((n % 2 == 0) ? v_even : v_odd);
    return d;
  endfunction

  task automatic send(int md, logic [8*IW-1:0] d, string t);
    @(negedge clk);
    in_valid = 1'b1;
    mode     = 4'(md);
    in_data  = d;
    cur_tag  = t;
  endtask

  task automatic idle(int cycles);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R6: watchdog expired, state=running expected=finished");
      finish_run();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    #2 rst_n = 1'b1;

    // R1: impulses on every lane, then random vectors, for all 8-point codes
    for (int md = 0; md < 5; md++) begin
      for (int n = 0; n < 8; n++) begin
        logic [8*IW-1:0] d;
        d = '0;
        d[n*IW +: IW] = IW'(n % 2 == 0 ? 100 : -77);
        send(md, d, "R1");
      end
      for (int r = 0; r < 16; r++) send(md, rnd_vec(), "R1");
    end
    idle(3);

    // R2: 4-point codes with random data on all lanes
    for (int md = 5; md < 10; md++) begin
      for (int r = 0; r < 12; r++) send(md, rnd_vec(), "R2");
    end
    // R4: only upper lanes loaded, lower lanes zero -> whole result zero
    for (int md = 5; md < 10; md++) begin
      logic [8*IW-1:0] d;
      d = rnd_vec();
      d[4*IW-1:0] = '0;
      send(md, d, "R4");
    end
    idle(3);

    // R3: halving rule with odd and negative inputs
    send(8, {16'(1), 16'(-1), 16'(5), 16'(3), 16'(-3), 16'(7), 16'(2), 16'(-5)}, "R3");
    send(8, {64'h0, 16'(-1), 16'(-1), 16'(-1), 16'(-1)}, "R3");
    send(8, {64'h0, 16'(32767), 16'(-32768), 16'(-32767), 16'(32767)}, "R3");
    for (int r = 0; r < 8; r++) send(8, rnd_vec(), "R3");
    idle(3);

    // R5: unassigned codes
    for (int md = 10; md < 16; md++) send(md, rnd_vec(), "R5");
    idle(3);

    // R7: full-scale patterns in the widest family and the others
    for (int md = 0; md < 10; md++) begin
      send(md, fill(32767, 32767), "R7");
      send(md, fill(-32768, -32768), "R7");
      send(md, fill(32767, -32768), "R7");
      send(md, fill(-32768, 32767), "R7");
    end
    idle(3);

    // R6: mixed stream with random gaps and codes
    for (int r = 0; r < 120; r++) begin
      @(negedge clk);
      in_valid = 1'($urandom_range(1));
      mode     = 4'($urandom_range(15));
      in_data  = rnd_vec();
      cur_tag  = "R6";
    end
    idle(6);

    finish_run();
  end

endmodule